// File: doc/BRIEF.md
# Highest-Priority Pending Interrupt Selector

This block serves one CPU interface of an interrupt distributor. Every interrupt line supplies its own state: enable, pending, active, group, an 8-bit priority and a mask of the CPUs it targets. The block searches all lines for the most urgent one that may be delivered to this CPU. It registers three results: the chosen interrupt ID, that interrupt's priority, and a request line to the processor.

The chosen ID is reported only when its priority beats the CPU's priority mask. The request additionally needs the priority to beat the CPU's current running priority. It also needs both the distributor-level and the CPU-level enable for the winner's group. Register programming, acknowledge and security filtering sit elsewhere, so all state arrives on input ports. Results appear one clock after the inputs they describe.

Top module: `pri_sel`

## Requirements
- R1: A line is a candidate only when its enable bit is 1, its pending bit is 1 and its active bit is 0.
- R2: A line with ID at or above PRIV_LINES (default 32) is a candidate only when its target mask ANDed with `cpu_sel` is non-zero.
- R3: A line with ID below PRIV_LINES ignores its target mask.
- R4: Among candidates, the numerically lowest priority wins. On equal priority the lowest ID wins.
- R5: With no candidate, `pend_id` is 1023, `pend_prio` is 0x100 and `irq_req` is 0.
- R6: `pend_prio` always carries the winner's priority, zero-extended to 9 bits. `pend_id` carries the winner's ID only when that priority is strictly below `prio_mask`; otherwise it is 1023 and `irq_req` is 0.
- R7: `irq_req` is 1 only when the winner's priority is strictly below `run_prio`, where 0x100 means idle.
- R8: `irq_req` is 1 only when bit g of `dist_grp_en` and bit g of `cpu_grp_en` are both 1, where g is the winner's group bit from `line_grp`.
- R9: Outputs are registered and reflect the inputs sampled at the previous rising clock edge. A synchronous active-low reset forces 1023, 0x100 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_sel | input | NUM_CPU | One-hot bit of this CPU |
| line_en | input | NUM_LINES | Per-line enable |
| line_pend | input | NUM_LINES | Per-line pending |
| line_act | input | NUM_LINES | Per-line active |
| line_grp | input | NUM_LINES | Per-line group (0 or 1) |
| line_prio | input | NUM_LINES*8 | Priority of line i in bits [8i+7:8i] |
| line_tgt | input | NUM_LINES*NUM_CPU | Target mask of line i in bits [NUM_CPU*i +: NUM_CPU] |
| prio_mask | input | 8 | CPU priority mask |
| run_prio | input | 9 | Running priority, 0x100 when idle |
| dist_grp_en | input | 2 | Distributor group enables, bit per group |
| cpu_grp_en | input | 2 | CPU interface group enables, bit per group |
| pend_id | output | 10 | Selected interrupt ID, 1023 when none |
| pend_prio | output | 9 | Winner priority, 0x100 when none |
| irq_req | output | 1 | Interrupt request to the CPU |

## Verification
A faulty comparison or eligibility term shows up one clock after the stimulus. It appears either as the wrong ID or priority on the outputs, or as a request raised against a masked, running-priority-blocked or group-disabled winner. Ties and exact-equality cases against the mask and the running priority are driven directly, because an off-by-one comparison is invisible elsewhere. Random states with narrow priority ranges force frequent ties, so an ordering fault cannot hide for long.

// File: rtl/pri_sel.sv
module pri_sel #(
  parameter int NUM_LINES  = 64,
  parameter int NUM_CPU    = 8,
  parameter int PRIV_LINES = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_CPU-1:0]             cpu_sel,
  input  logic [NUM_LINES-1:0]           line_en,
  input  logic [NUM_LINES-1:0]           line_pend,
  input  logic [NUM_LINES-1:0]           line_act,
  input  logic [NUM_LINES-1:0]           line_grp,
  input  logic [NUM_LINES*8-1:0]         line_prio,
  input  logic [NUM_LINES*NUM_CPU-1:0]   line_tgt,
  input  logic [7:0]                     prio_mask,
  input  logic [8:0]                     run_prio,
  input  logic [1:0]                     dist_grp_en,
  input  logic [1:0]                     cpu_grp_en,
  output logic [9:0]                     pend_id,
  output logic [8:0]                     pend_prio,
  output logic                           irq_req
);
  localparam logic [9:0] NONE_ID   = 10'd1023;
  localparam logic [8:0] NONE_PRIO = 9'h100;

  logic [NUM_LINES-1:0] cand;
  logic [9:0] best_id;
  logic [8:0] best_prio;
  logic       best_grp;

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_cand
      if (g < PRIV_LINES) begin : g_priv
        assign cand[g] = line_en[g] & line_pend[g] & ~line_act[g];
      end else begin : g_shr
        assign cand[g] = line_en[g] & line_pend[g] & ~line_act[g] &
                         (|(line_tgt[g*NUM_CPU +: NUM_CPU] & cpu_sel));
      end
    end
  endgenerate

  always_comb begin
    best_id   = NONE_ID;
    best_prio = NONE_PRIO;
    best_grp  = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (cand[i] && ({1'b0, line_prio[i*8 +: 8]} < best_prio)) begin
        best_prio = {1'b0, line_prio[i*8 +: 8]};
        best_id   = 10'(i);
        best_grp  = line_grp[i];
      end
    end
  end

  wire beats_mask = best_prio < {1'b0, prio_mask};
  wire beats_run  = best_prio < run_prio;
  wire grp_ok     = dist_grp_en[best_grp] & cpu_grp_en[best_grp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_id   <= NONE_ID;
      pend_prio <= NONE_PRIO;
      irq_req   <= 1'b0;
    end else begin
      pend_id   <= beats_mask ? best_id : NONE_ID;
      pend_prio <= best_prio;
      irq_req   <= beats_mask & beats_run & grp_ok;
    end
  end
endmodule

// File: rtl/pri_sel_chk.sv
module pri_sel_chk #(
  parameter int NUM_LINES = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] line_en,
  input logic [NUM_LINES-1:0] line_pend,
  input logic [NUM_LINES-1:0] line_act,
  input logic [NUM_LINES-1:0] line_grp,
  input logic [7:0]           prio_mask,
  input logic [8:0]           run_prio,
  input logic [1:0]           dist_grp_en,
  input logic [1:0]           cpu_grp_en,
  input logic [9:0]           pend_id,
  input logic [8:0]           pend_prio,
  input logic                 irq_req
);
  localparam int IW = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0] q_ok, q_grp;
  logic [1:0] q_dg, q_cg;
  always_ff @(posedge clk) begin
    q_ok  <= line_en & line_pend & ~line_act;
    q_grp <= line_grp;
    q_dg  <= dist_grp_en;
    q_cg  <= cpu_grp_en;
  end

  assert_req_has_id_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> pend_id != 10'd1023);
  assert_req_below_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> pend_prio < $past(run_prio));
  assert_id_below_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_id != 10'd1023) |-> pend_prio < {1'b0, $past(prio_mask)});
  assert_idle_prio_no_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_prio == 9'h100) |-> (pend_id == 10'd1023 && !irq_req));
  assert_winner_eligible_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_id != 10'd1023) |-> q_ok[pend_id[IW-1:0]]);
  assert_group_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (q_dg[q_grp[pend_id[IW-1:0]]] && q_cg[q_grp[pend_id[IW-1:0]]]));
endmodule

bind pri_sel pri_sel_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_en(line_en), .line_pend(line_pend),
  .line_act(line_act), .line_grp(line_grp), .prio_mask(prio_mask),
  .run_prio(run_prio), .dist_grp_en(dist_grp_en), .cpu_grp_en(cpu_grp_en),
  .pend_id(pend_id), .pend_prio(pend_prio), .irq_req(irq_req));

// File: tb/pri_sel_test.sv
module pri_sel_test;
  localparam int PERIOD = 10;
  localparam int NL = 64;
  localparam int NC = 8;
  localparam int NP = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0] cpu_sel = 8'b0000_0100;
  logic [NL-1:0] en, pend, act, grp;
  logic [NL*8-1:0] prio;
  logic [NL*NC-1:0] tgt;
  logic [7:0] mask;
  logic [8:0] run;
  logic [1:0] dg, cg;
  logic [9:0] pend_id;
  logic [8:0] pend_prio;
  logic irq_req;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  pri_sel #(.NUM_LINES(NL), .NUM_CPU(NC), .PRIV_LINES(NP)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .line_en(en), .line_pend(pend),
    .line_act(act), .line_grp(grp), .line_prio(prio), .line_tgt(tgt),
    .prio_mask(mask), .run_prio(run), .dist_grp_en(dg), .cpu_grp_en(cg),
    .pend_id(pend_id), .pend_prio(pend_prio), .irq_req(irq_req));

  task automatic chk(input string tag, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  task automatic clear_all();
    en = '0; pend = '0; act = '0; grp = '0; prio = '1; tgt = '0;
    mask = 8'hFF; run = 9'h100; dg = 2'b11; cg = 2'b11;
  endtask

  task automatic put(input int i, input logic a, input logic g, input int p, input logic [NC-1:0] t);
    en[i] = 1'b1; pend[i] = 1'b1; act[i] = a; grp[i] = g;
    prio[i*8 +: 8] = 8'(p); tgt[i*NC +: NC] = t;
  endtask

  function automatic void model(output int id, output int pr, output int rq);
    int bp = 256;
    int bi = 1023;
    int bg = 0;
    for (int i = 0; i < NL; i++) begin
      if (en[i] && pend[i] && !act[i] && (i < NP || (tgt[i*NC +: NC] & cpu_sel) != 0)) begin
        if (int'(prio[i*8 +: 8]) < bp) begin
          bp = int'(prio[i*8 +: 8]); bi = i; bg = int'(grp[i]);
        end
      end
    end
    pr = bp;
    id = (bp < int'(mask)) ? bi : 1023;
    rq = (bp < int'(mask) && bp < int'(run) && dg[bg] && cg[bg]) ? 1 : 0;
  endfunction

  task automatic step_check(input string tag);
    int eid, epr, erq;
    model(eid, epr, erq);
    @(posedge clk);
    #(PERIOD/4);
    chk({tag, " id"}, int'(pend_id), eid);
    chk({tag, " prio"}, int'(pend_prio), epr);
    chk({tag, " req"}, int'(irq_req), erq);
  endtask

  task automatic step_expect(input string tag, input int eid, input int epr, input int erq);
    @(posedge clk);
    #(PERIOD/4);
    chk({tag, " id"}, int'(pend_id), eid);
    chk({tag, " prio"}, int'(pend_prio), epr);
    chk({tag, " req"}, int'(irq_req), erq);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_all();
    put(3, 1'b0, 1'b0, 5, '0);
    rst_n = 1'b0;
    step_expect("R9 reset", 1023, 256, 0);
    step_expect("R9 reset hold", 1023, 256, 0);
    rst_n = 1'b1;
    step_expect("R9 one cycle after reset", 3, 5, 1);

    clear_all();
    step_expect("R5 no candidates", 1023, 256, 0);

    clear_all(); put(7, 1'b1, 1'b0, 1, '0); put(9, 1'b0, 1'b0, 50, '0);
    en[12] = 1'b1; prio[12*8 +: 8] = 8'd0;
    step_expect("R1 active/unpending skipped", 9, 50, 1);

    clear_all(); put(40, 1'b0, 1'b0, 2, 8'b0000_1000); put(41, 1'b0, 1'b0, 9, 8'b0000_0100);
    step_expect("R2 target miss skipped", 41, 9, 1);

    clear_all(); put(5, 1'b0, 1'b0, 30, '0); put(45, 1'b0, 1'b0, 20, '0);
    step_expect("R3 private ignores target", 5, 30, 1);

    clear_all(); put(20, 1'b0, 1'b0, 8, '0); put(10, 1'b0, 1'b0, 8, '0); put(50, 1'b0, 1'b0, 8, 8'hFF);
    step_expect("R4 tie lowest id", 10, 8, 1);

    clear_all(); put(60, 1'b0, 1'b0, 3, 8'hFF); put(2, 1'b0, 1'b0, 4, '0);
    step_expect("R4 lower value wins", 60, 3, 1);

    clear_all(); put(6, 1'b0, 1'b0, 16, '0); mask = 8'd16;
    step_expect("R6 equal to mask", 1023, 16, 0);
    mask = 8'd17;
    step_expect("R6 just below mask", 6, 16, 1);

    run = 9'd16;
    step_expect("R7 equal running", 6, 16, 0);
    run = 9'd17;
    step_expect("R7 below running", 6, 16, 1);

    clear_all(); put(33, 1'b0, 1'b1, 1, 8'b0000_0100); put(34, 1'b0, 1'b0, 2, 8'b0000_0100);
    dg = 2'b01;
    step_expect("R8 dist group1 off", 33, 1, 0);
    dg = 2'b11; cg = 2'b01;
    step_expect("R8 cpu group1 off", 33, 1, 0);
    cg = 2'b10;
    step_expect("R8 group1 on", 33, 1, 1);

    for (int n = 0; n < 400; n++) begin
      en = {$urandom, $urandom}; pend = {$urandom, $urandom};
      act = {$urandom, $urandom} & {$urandom, $urandom};
      grp = {$urandom, $urandom};
      for (int i = 0; i < NL; i++) begin
        prio[i*8 +: 8] = (n % 2 == 0) ? 8'($urandom_range(0, 7)) : 8'($urandom);
        tgt[i*NC +: NC] = 8'($urandom);
      end
      mask = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom);
      run = 9'($urandom_range(0, 256));
      dg = 2'($urandom); cg = 2'($urandom);
      step_check("R4 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule